// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block sits between a 32-bit processor core and a word-wide synchronous data memory. Each request carries a 6-bit operation code, a base register value, a signed 16-bit displacement and, for stores, a source register value. The unit adds the base and the sign-extended displacement to form a byte address. It drives the word address of the memory port and, for stores, four byte-write enables and the write word with the data on the correct byte lane.

Lanes follow big-endian order: byte offset 0 within a word is bits 31:24 and offset 3 is bits 7:0. A byte load takes the selected lane of the returned word into bits 7:0 of the result and sign-extends it. A byte store writes one lane and leaves the other three untouched. Word accesses whose address is not a multiple of four raise a misalign flag, and no memory access is made for them. The memory returns read data one clock after it samples the address. The unit delays the lane selection to match that latency.

Top module: `lsu_lane_unit`

## Requirements
- R1: The byte address is `base_val` plus `offset` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` carries bits 31:2 of that address in the cycle after a request that makes a memory access.
- R2: Opcode 35 is word load, 43 is word store, 32 is byte load and 40 is byte store. Any other opcode, and any cycle with `req_valid` low, makes no access: `mem_re` stays 0, `mem_we` stays 0 and no `load_valid` pulse follows.
- R3: An aligned word store drives `mem_we` = 4'b1111 and `mem_wdata` = `store_data` in the cycle after the request.
- R4: A byte store drives exactly one enable. Address bits 1:0 = k select `mem_we` bit 3-k and lane bits (31-8k):(24-8k). `mem_wdata` carries `store_data[7:0]` on all four lanes, so the other three bytes of the memory word keep their value.
- R5: A byte load returns the lane chosen by address bits 1:0, in the lane order of R4. The byte sits in `load_data[7:0]`, and its bit 7 is copied into bits 31:8.
- R6: An aligned word load returns the whole memory word unchanged on `load_data`.
- R7: A word load or store with address bits 1:0 nonzero sets `misalign` for one cycle, in the cycle after the request. It asserts no write enable, starts no read and produces no `load_valid`. Byte accesses never set `misalign`.
- R8: For a load, `mem_re` is high in the cycle after the request. `load_valid` pulses and `load_data` is valid two cycles after that, which is one cycle after the memory returns the word.
- R9: While `rst` is high, all outputs are 0, and a load that is in flight when reset arrives produces no `load_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Operation code (see R2) |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Byte-write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write word with lanes placed |
| mem_rdata | input | 32 | Read word, one cycle after `mem_re` |
| misalign | output | 1 | Misaligned word access flag |
| load_valid | output | 1 | Load result strobe |
| load_data | output | 32 | Aligned, extended load result |

## Verification
A request is captured on a rising edge. `mem_addr`, `mem_re`, `mem_we`, `mem_wdata` and `misalign` change right after that edge, and the bench samples them on the next falling edge. The memory model answers on the following rising edge, and the load result is registered one edge after that. The bench therefore lets two more rising edges pass and samples `load_data` on the falling edge that follows. For non-loads it confirms that `load_valid` stays low at that same point. Byte stores are judged by reading the word back later against a shadow copy that the bench keeps from the requirements, which exposes any write to a neighbouring lane.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN     = 32;
  localparam int DISP_W   = 16;
  localparam int OPC_W    = 6;
  localparam int BYTE_W   = 8;
  localparam int LANES    = XLEN / BYTE_W;
  localparam int LANE_W   = $clog2(LANES);

  typedef enum logic [OPC_W-1:0] {
    OPC_LDB = 6'd32,
    OPC_LDW = 6'd35,
    OPC_STB = 6'd40,
    OPC_STW = 6'd43
  } mem_opc_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              narrow;
    logic [LANE_W-1:0] lane;
  } acc_ctl_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int CW = 6
) (
  input  logic          valid,
  input  logic [CW-1:0] opcode,
  input  logic [DW-1:0] base,
  input  logic [OW-1:0] disp,
  output logic [DW-1:0] ea,
  output acc_ctl_t      ctl,
  output logic          bad_align
);
  localparam int EXT_W = DW - OW;
  localparam int LW    = $clog2(DW / 8);

  logic is_ldw, is_stw, is_ldb, is_stb;
  logic word_op;

  always_comb begin
    is_ldw  = valid && (opcode == CW'(OPC_LDW));
    is_stw  = valid && (opcode == CW'(OPC_STW));
    is_ldb  = valid && (opcode == CW'(OPC_LDB));
    is_stb  = valid && (opcode == CW'(OPC_STB));
    word_op = is_ldw || is_stw;
    ea      = base + {{EXT_W{disp[OW-1]}}, disp};
    bad_align = word_op && (ea[LW-1:0] != '0);
    ctl.rd     = (is_ldw || is_ldb) && !bad_align;
    ctl.wr     = (is_stw || is_stb) && !bad_align;
    ctl.narrow = is_ldb || is_stb;
    ctl.lane   = ea[LW-1:0];
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NL = DW / BW,
  localparam int LW = $clog2(NL)
) (
  input  logic          narrow,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] src,
  output logic [NL-1:0] be,
  output logic [DW-1:0] wword
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    // big-endian: enable bit i serves byte offset NL-1-i
    localparam logic [LW-1:0] OFS = LW'(NL - 1 - i);
    assign be[i] = narrow ? (lane == OFS) : 1'b1;
    assign wword[i*BW +: BW] = narrow ? src[BW-1:0] : src[i*BW +: BW];
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NL = DW / BW,
  localparam int LW = $clog2(NL)
) (
  input  logic          narrow,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] value
);
  logic [BW-1:0] lanes [NL];
  logic [BW-1:0] pick;

  for (genvar k = 0; k < NL; k++) begin : g_split
    // offset k lives at the k-th byte counted from the top
    assign lanes[k] = word[DW-1-k*BW -: BW];
  end

  always_comb begin
    pick  = lanes[lane];
    value = narrow ? {{(DW-BW){pick[BW-1]}}, pick} : word;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int CW = 6,
  parameter int BW = 8,
  localparam int NL = DW / BW,
  localparam int LW = $clog2(NL),
  localparam int AW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [CW-1:0] req_opcode,
  input  logic [DW-1:0] base_val,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] store_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic [NL-1:0] mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          misalign,
  output logic          load_valid,
  output logic [DW-1:0] load_data
);
  logic [DW-1:0] ea;
  acc_ctl_t      ctl;
  logic          bad_align;
  logic [NL-1:0] be;
  logic [DW-1:0] wword;

  lsu_addr_gen #(.DW(DW), .OW(OW), .CW(CW)) u_agen (
    .valid(req_valid), .opcode(req_opcode), .base(base_val), .disp(offset),
    .ea(ea), .ctl(ctl), .bad_align(bad_align)
  );

  lsu_store_lane #(.DW(DW), .BW(BW)) u_slane (
    .narrow(ctl.narrow), .lane(ctl.lane), .src(store_data),
    .be(be), .wword(wword)
  );

  // stage 1: memory port, registered
  logic          s1_narrow;
  logic [LW-1:0] s1_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= '0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s1_narrow <= 1'b0;
      s1_lane   <= '0;
    end else begin
      mem_re    <= ctl.rd;
      mem_we    <= ctl.wr ? be : '0;
      misalign  <= bad_align;
      if (ctl.rd || ctl.wr) begin
        mem_addr  <= ea[DW-1:LW];
        mem_wdata <= wword;
        s1_narrow <= ctl.narrow;
        s1_lane   <= ctl.lane;
      end
    end
  end

  // stage 2: lane control aligned with returning read word
  logic          s2_rd;
  logic          s2_narrow;
  logic [LW-1:0] s2_lane;
  logic [DW-1:0] aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_rd     <= 1'b0;
      s2_narrow <= 1'b0;
      s2_lane   <= '0;
    end else begin
      s2_rd     <= mem_re;
      s2_narrow <= s1_narrow;
      s2_lane   <= s1_lane;
    end
  end

  lsu_load_lane #(.DW(DW), .BW(BW)) u_llane (
    .narrow(s2_narrow), .lane(s2_lane), .word(mem_rdata), .value(aligned)
  );

  // stage 3: registered load result
  logic s3_narrow;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_valid <= 1'b0;
      load_data  <= '0;
      s3_narrow  <= 1'b0;
    end else begin
      load_valid <= s2_rd;
      if (s2_rd) begin
        load_data <= aligned;
        s3_narrow <= s2_narrow;
      end
    end
  end

  // R4
  byte_we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we != '1) |-> $onehot0(mem_we));

  // R7
  misalign_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (mem_we == '0) && !mem_re);

  // R2
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && (mem_we != '0)));

  // R8
  load_latency_chk: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(s2_rd) && $past(mem_re, 2));

  // R5
  byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (load_valid && s3_narrow) |-> (load_data[DW-1:BW] == {(DW-BW){load_data[BW-1]}}));
endmodule

// File: tb/sim_lsu_lane_unit.sv
module sim_lsu_lane_unit;
  localparam int CLK_T = 10;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sdat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{6'd43, 32'h0000_0100, 16'h0000, 32'h1122_3344}, // R3 store word
    '{6'd35, 32'h0000_0104, 16'hFFFC, 32'h0},         // R1 R6 negative disp
    '{6'd40, 32'h0000_0100, 16'h0001, 32'hFFFF_FFAB}, // R4 lane 1
    '{6'd35, 32'h0000_0100, 16'h0000, 32'h0},         // R4 readback
    '{6'd32, 32'h0000_0100, 16'h0001, 32'h0},         // R5 negative byte
    '{6'd32, 32'h0000_0100, 16'h0000, 32'h0},         // R5 offset 0 = MSB
    '{6'd32, 32'h0000_0103, 16'h0000, 32'h0},         // R5 offset 3 = LSB
    '{6'd40, 32'h0000_0FE0, 16'h0013, 32'h1234_567E}, // R4 lane 3
    '{6'd32, 32'h0000_0FF0, 16'h0003, 32'h0},         // R5
    '{6'd43, 32'h0000_0102, 16'h0000, 32'hDEAD_BEEF}, // R7 store
    '{6'd35, 32'h0000_0101, 16'h0000, 32'h0},         // R7 load
    '{6'd00, 32'h0000_0100, 16'h0000, 32'hCAFE_F00D}, // R2 other opcode
    '{6'd35, 32'h0000_0100, 16'h0000, 32'h0},         // R7 no write seen
    '{6'd40, 32'h0000_7FFC, 16'h8000, 32'h0000_0080}, // R1 wrap, lane 0
    '{6'd32, 32'hFFFF_FFFC, 16'h0000, 32'h0}          // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_opcode = '0;
  logic [31:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [29:0] mem_addr;
  logic        mem_re;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mem    [DEPTH];
  logic [31:0] shadow [DEPTH];

  always #(CLK_T/2) clk = ~clk;

  lsu_lane_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .base_val(base_val), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
    .load_valid(load_valid), .load_data(load_data)
  );

  // memory model: byte enables, one cycle read latency
  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (mem_we[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] ea, word, exp_ld;
    logic [1:0]  ofs;
    logic        ldw, stw, ldb, stb, mis, exp_re;
    logic [3:0]  exp_we;
    logic [7:0]  bsel;
    ea  = v.base + {{16{v.off[15]}}, v.off};
    ofs = ea[1:0];
    ldw = v.op == 6'd35; stw = v.op == 6'd43;
    ldb = v.op == 6'd32; stb = v.op == 6'd40;
    mis = (ldw || stw) && ofs != 2'd0;
    exp_re = (ldw || ldb) && !mis;
    exp_we = (stw && !mis) ? 4'hF : stb ? (4'b0001 << (3 - ofs)) : 4'h0;
    word = shadow[ea[5:2]];
    bsel = word[31 - 8*ofs -: 8];
    exp_ld = ldb ? {{24{bsel[7]}}, bsel} : word;

    @(negedge clk);
    req_valid = 1'b1; req_opcode = v.op; base_val = v.base;
    offset = v.off; store_data = v.sdat;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 misalign", {31'd0, misalign}, {31'd0, mis});
    chk("R2 mem_re", {31'd0, mem_re}, {31'd0, exp_re});
    chk("R4 mem_we", {28'd0, mem_we}, {28'd0, exp_we});
    if (exp_re || exp_we != 0) chk("R1 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
    if (stw && !mis) chk("R3 wdata", mem_wdata, v.sdat);
    if (stb) chk("R4 wdata", mem_wdata, {4{v.sdat[7:0]}});
    if (stw && !mis) shadow[ea[5:2]] = v.sdat;
    if (stb) begin
      word[31 - 8*ofs -: 8] = v.sdat[7:0];
      shadow[ea[5:2]] = word;
    end
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R8 load_valid", {31'd0, load_valid}, {31'd0, exp_re});
    if (exp_re) chk(ldb ? "R5 byte load" : "R6 word load", load_data, exp_ld);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = 32'hC0DE_0000 | i;
      shadow[i] = 32'hC0DE_0000 | i;
    end
    mem_rdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 mem_re", {31'd0, mem_re}, 32'd0);
    chk("R9 mem_we", {28'd0, mem_we}, 32'd0);
    chk("R9 load_valid", {31'd0, load_valid}, 32'd0);
    chk("R9 load_data", load_data, 32'd0);
    chk("R9 misalign", {31'd0, misalign}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 reset while a load is in flight
    @(negedge clk);
    req_valid = 1'b1; req_opcode = 6'd35; base_val = 32'h100; offset = '0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mem_re after reset", {31'd0, mem_re}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 no load_valid", {31'd0, load_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 no late load_valid", {31'd0, load_valid}, 32'd0);

    // R2 idle cycle with a legal opcode but req_valid low
    @(negedge clk);
    req_valid = 1'b0; req_opcode = 6'd43; store_data = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle mem_we", {28'd0, mem_we}, 32'd0);
    chk("R2 idle mem_re", {31'd0, mem_re}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule